// File: doc/BRIEF.md
# Base-Limit Relocation and Protection Unit

This unit sits between a processor's address output and the memory system. For each access made in user mode it adds a relocation base to the logical address to form the physical address, and it checks the logical address against a limit. An access that fails the check is turned into a fault, so nothing goes to memory. In kernel mode the logical address goes through unchanged and no bound check is made.

The base and limit values sit in two registers. Only a write made while the mode bit says kernel can load them, which is what the kernel does on a context switch. A write attempted from user mode leaves both registers as they were and raises a one-cycle privilege-error pulse. The translation path is registered, so the result of a request appears one cycle after its strobe.

Top module: `reloc_guard`

## Requirements
- R1: After reset, base and limit are 0, and `valid_o`, `fault_o` and `priv_err_o` are low. The first user access after reset faults.
- R2: A legal user request sampled at a clock edge gives `valid_o`=1 and `paddr_o` = base + logical address, modulo 2^PADDR_W, right after that edge.
- R3: A user request whose zero-extended logical address is greater than or equal to the limit gives `fault_o`=1, `valid_o`=0 and `paddr_o`=0 one cycle later.
- R4: The bound is strict. A logical address equal to limit-1 is legal, and one equal to the limit faults.
- R5: A request with `kernel_i`=1 gives `valid_o`=1 and `paddr_o` equal to the logical address zero-extended, whatever the base and limit are.
- R6: A write with `kernel_i`=1 and `cfg_we_i`=1 loads `cfg_wdata_i` into the base when `cfg_sel_i`=0, or into the limit when `cfg_sel_i`=1.
- R7: A write with `kernel_i`=0 changes neither register. It sets `priv_err_o` high for exactly the one cycle that follows.
- R8: A cycle with no request strobe gives `valid_o`=0 and `fault_o`=0 one cycle later.
- R9: A kernel register write applies to requests from the next cycle on.
- R10: `valid_o` and `fault_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Access request strobe |
| kernel_i | input | 1 | Mode bit: 1 = kernel, 0 = user |
| laddr_i | input | LADDR_W | Logical address |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_sel_i | input | 1 | Register select: 0 = base, 1 = limit |
| cfg_wdata_i | input | PADDR_W | Register write data |
| paddr_o | output | PADDR_W | Physical address, registered |
| valid_o | output | 1 | Access accepted, registered |
| fault_o | output | 1 | Access refused, registered |
| priv_err_o | output | 1 | User-mode register write was refused |

## Verification
The base and limit registers cannot be read back. A wrong base therefore shows up only as an offset error in `paddr_o`, and a wrong limit only as a move in the fault boundary. Both appear on the first user request after the corruption, one cycle after its strobe. For that reason the boundary is probed at limit-1 and at the limit exactly. A refused user write is followed by a user request, so that any change to the base would show at the ports in the next cycle.

// File: rtl/reloc_pkg.sv
package reloc_pkg;
  typedef enum logic {
    MODE_USER   = 1'b0,
    MODE_KERNEL = 1'b1
  } mode_e;

  typedef enum logic {
    SEL_BASE  = 1'b0,
    SEL_LIMIT = 1'b1
  } cfg_sel_e;
endpackage

// File: rtl/reloc_cfg_regs.sv
module reloc_cfg_regs
  import reloc_pkg::*;
#(
  parameter int unsigned REG_W = 17
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic             mode_i,
  input  logic             sel_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] base_o,
  output logic [REG_W-1:0] limit_o,
  output logic             priv_err_o
);
  logic [REG_W-1:0] base_q, limit_q;
  logic             priv_q;
  logic             wr_ok, wr_bad;

  assign wr_ok  = we_i && (mode_i == MODE_KERNEL);
  assign wr_bad = we_i && (mode_i == MODE_USER);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q  <= '0;
      limit_q <= '0;
      priv_q  <= 1'b0;
    end else begin
      priv_q <= wr_bad;
      if (wr_ok && sel_i == SEL_BASE)  base_q  <= wdata_i;
      if (wr_ok && sel_i == SEL_LIMIT) limit_q <= wdata_i;
    end
  end

  assign base_o     = base_q;
  assign limit_o    = limit_q;
  assign priv_err_o = priv_q;

  p_user_wr_ignored_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && mode_i == MODE_USER) |=> ($stable(base_q) && $stable(limit_q)));
  p_priv_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && mode_i == MODE_USER) |=> priv_err_o);
  p_base_load_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && mode_i == MODE_KERNEL && sel_i == SEL_BASE) |=> (base_o == $past(wdata_i)));
  p_limit_load_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && mode_i == MODE_KERNEL && sel_i == SEL_LIMIT) |=> (limit_o == $past(wdata_i)));
endmodule

// File: rtl/reloc_xlate.sv
module reloc_xlate
  import reloc_pkg::*;
#(
  parameter int unsigned LADDR_W = 16,
  parameter int unsigned PADDR_W = 17
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               mode_i,
  input  logic [LADDR_W-1:0] laddr_i,
  input  logic [PADDR_W-1:0] base_i,
  input  logic [PADDR_W-1:0] limit_i,
  output logic [PADDR_W-1:0] paddr_o,
  output logic               valid_o,
  output logic               fault_o
);
  localparam int unsigned EXT_W = PADDR_W - LADDR_W;

  logic [PADDR_W-1:0] ext_addr, reloc_sum, paddr_d;
  logic               in_bound, accept, refuse;

  assign ext_addr  = {{EXT_W{1'b0}}, laddr_i};
  assign reloc_sum = base_i + ext_addr;
  assign in_bound  = ext_addr < limit_i;

  always_comb begin
    accept  = 1'b0;
    refuse  = 1'b0;
    paddr_d = '0;
    if (req_i) begin
      if (mode_i == MODE_KERNEL) begin
        accept  = 1'b1;
        paddr_d = ext_addr;
      end else if (in_bound) begin
        accept  = 1'b1;
        paddr_d = reloc_sum;
      end else begin
        refuse  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      paddr_o <= '0;
      valid_o <= 1'b0;
      fault_o <= 1'b0;
    end else begin
      paddr_o <= paddr_d;
      valid_o <= accept;
      fault_o <= refuse;
    end
  end

  p_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_o && fault_o));
  p_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> (!valid_o && !fault_o));
  p_kernel_pass_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && mode_i == MODE_KERNEL) |=> (valid_o && paddr_o == $past(ext_addr)));
  p_user_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && mode_i == MODE_USER && ext_addr >= limit_i) |=> (fault_o && paddr_o == '0));
endmodule

// File: rtl/reloc_guard.sv
module reloc_guard
  import reloc_pkg::*;
#(
  parameter int unsigned LADDR_W = 16,
  parameter int unsigned PADDR_W = 17
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  input  logic               kernel_i,
  input  logic [LADDR_W-1:0] laddr_i,
  input  logic               cfg_we_i,
  input  logic               cfg_sel_i,
  input  logic [PADDR_W-1:0] cfg_wdata_i,
  output logic [PADDR_W-1:0] paddr_o,
  output logic               valid_o,
  output logic               fault_o,
  output logic               priv_err_o
);
  generate
    if (PADDR_W <= LADDR_W) begin : g_bad_width
      $error("PADDR_W must exceed LADDR_W");
    end
  endgenerate

  logic [PADDR_W-1:0] base_w, limit_w;

  reloc_cfg_regs #(.REG_W(PADDR_W)) i_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (cfg_we_i),
    .mode_i     (kernel_i),
    .sel_i      (cfg_sel_i),
    .wdata_i    (cfg_wdata_i),
    .base_o     (base_w),
    .limit_o    (limit_w),
    .priv_err_o (priv_err_o)
  );

  reloc_xlate #(.LADDR_W(LADDR_W), .PADDR_W(PADDR_W)) i_xlate (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req_valid_i),
    .mode_i  (kernel_i),
    .laddr_i (laddr_i),
    .base_i  (base_w),
    .limit_i (limit_w),
    .paddr_o (paddr_o),
    .valid_o (valid_o),
    .fault_o (fault_o)
  );
endmodule

// File: tb/test_reloc_guard.sv
`timescale 1ns/1ps
module test_reloc_guard;
  localparam int LW = 16;
  localparam int PW = 17;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0, kern = 1'b0, we = 1'b0, sel = 1'b0;
  logic [LW-1:0] la = '0;
  logic [PW-1:0] wd = '0;
  logic [PW-1:0] paddr;
  logic          valid, fault, perr;
  int            checks = 0, errors = 0;
  bit            done = 0;

  always #2 clk = ~clk;

  reloc_guard #(.LADDR_W(LW), .PADDR_W(PW)) i_reloc_guard (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req), .kernel_i(kern),
    .laddr_i(la), .cfg_we_i(we), .cfg_sel_i(sel), .cfg_wdata_i(wd),
    .paddr_o(paddr), .valid_o(valid), .fault_o(fault), .priv_err_o(perr)
  );

  // {kernel, laddr, exp_valid, exp_fault, exp_paddr}; base 0x01000, limit 0x00200
  localparam logic [35:0] VEC [8] = '{
    {1'b0, 16'h0000, 1'b1, 1'b0, 17'h01000},
    {1'b0, 16'h0123, 1'b1, 1'b0, 17'h01123},
    {1'b0, 16'h01FF, 1'b1, 1'b0, 17'h011FF},
    {1'b0, 16'h0200, 1'b0, 1'b1, 17'h00000},
    {1'b0, 16'hFFFF, 1'b0, 1'b1, 17'h00000},
    {1'b1, 16'hFFFF, 1'b1, 1'b0, 17'h0FFFF},
    {1'b1, 16'h0200, 1'b1, 1'b0, 17'h00200},
    {1'b0, 16'h0042, 1'b1, 1'b0, 17'h01042}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(input logic k, input logic [LW-1:0] a);
    @(negedge clk);
    req = 1'b1; kern = k; la = a;
    @(posedge clk); #1;
    req = 1'b0;
  endtask

  task automatic cfg_write(input logic k, input logic s, input logic [PW-1:0] d);
    @(negedge clk);
    we = 1'b1; kern = k; sel = s; wd = d;
    @(posedge clk); #1;
    we = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 valid after reset", valid, 0);
    check("R1 fault after reset", fault, 0);
    check("R1 priv_err after reset", perr, 0);
    @(negedge clk); rst_n = 1'b1;
    access(1'b0, 16'h0000);
    check("R1 first user access faults", fault, 1);
    check("R1 first user access not valid", valid, 0);

    cfg_write(1'b1, 1'b0, 17'h01000);  // R6 base
    cfg_write(1'b1, 1'b1, 17'h00200);  // R6 limit
    check("R6 kernel write no priv_err", perr, 0);

    for (int i = 0; i < 8; i++) begin
      logic [35:0] v;
      v = VEC[i];
      access(v[35], v[34:19]);
      check($sformatf("R2/R3/R4/R5 vec%0d valid", i), valid, v[18]);
      check($sformatf("R2/R3/R4/R5 vec%0d fault", i), fault, v[17]);
      check($sformatf("R2/R3/R4/R5 vec%0d paddr", i), paddr, v[16:0]);
      check($sformatf("R10 vec%0d exclusive", i), valid & fault, 0);
    end

    // R8 idle
    @(negedge clk); @(posedge clk); #1;
    check("R8 idle valid", valid, 0);
    check("R8 idle fault", fault, 0);

    // R7 user write refused
    cfg_write(1'b0, 1'b0, 17'h03000);
    check("R7 priv_err pulse", perr, 1);
    access(1'b0, 16'h0010);
    check("R7 priv_err drops", perr, 0);
    check("R7 base unchanged paddr", paddr, 17'h01010);
    cfg_write(1'b0, 1'b1, 17'h1FFFF);
    access(1'b0, 16'h0200);
    check("R7 limit unchanged fault", fault, 1);

    // R2 wraparound
    cfg_write(1'b1, 1'b0, 17'h1FF00);
    cfg_write(1'b1, 1'b1, 17'h10000);
    access(1'b0, 16'h0200);
    check("R2 wrap valid", valid, 1);
    check("R2 wrap paddr", paddr, 17'h00100);
    access(1'b0, 16'hFFFF);
    check("R4 full-range limit last addr valid", valid, 1);

    // R9 write applies from next cycle
    cfg_write(1'b1, 1'b1, 17'h00000);
    access(1'b0, 16'h0000);
    check("R9 new limit applies next cycle", fault, 1);
    access(1'b1, 16'h0005);
    check("R5 kernel ignores zero limit", valid, 1);
    check("R5 kernel paddr", paddr, 17'h00005);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule